// File: doc/BRIEF.md
# Touch-Key Register Map I2C Target

This block is the host-facing side of a multi-key capacitive touch controller. It is an I2C target at a fixed 7-bit address. A host reaches a byte-addressed table through it. The table holds an identity byte, a firmware version byte, two live status bytes, a 16-bit signal and a 16-bit reference value for every key, and a bank of writable per-key settings. The settings bank also contains two command locations. A nonzero write to either one is turned into a single-cycle calibrate or reset request toward the sensing core.

A transfer first sends a memory address. Write data then lands at consecutive locations. A later read, after a repeated START or after STOP then START, streams bytes from that remembered address for as long as the host acknowledges. The block keeps an active-low change output that tells the host the status bytes have moved. The host releases it by reading status. For a time after reset the target ignores its own address. Once a longer delay has passed, it raises the change output once to announce that it is ready.

SCL and SDA are oversampled on the system clock. Clock stretching, the analog pads and the sensing front end are outside the block.

Top module: `keymap_i2c_target`

## Requirements
- R1: Only the 7-bit device address 0x1B (write byte 0x36, read byte 0x37) is acknowledged. Any other device address gets no ACK, and the target stays silent until the next START.
- R2: A memory-address byte below 0x80 is ACKed and a byte of 0x80 or above is NACKed. Every data byte written after a NACKed memory address is also NACKed, and no location changes.
- R3: Write data bytes go to consecutive addresses, starting at the memory address. Only 0x20 to 0x39 can be written. Data bytes aimed at any other address below 0x80 are ACKed and discarded. Locations 0x20 to 0x37 read back what was written, and their bytes also appear on cfg_o, with location 0x20+i at bits 8i+7:8i.
- R4: A read returns consecutive addresses for as long as the host ACKs each byte, and it ends at the first host NACK.
- R5: Each read transfer starts at the memory address the host sent most recently. This holds whether the read follows a repeated START or a STOP and a new START.
- R6: Read contents are as follows. Address 0 is 0x2E. Address 1 is the firmware version parameter (default 0x15). Address 2 is det_status_i. Address 3 is key_status_i with bit 7 zero. The signal of key k sits at 4+2k (high byte) and 5+2k (low byte). The reference of key k sits at 18+2k (high byte) and 19+2k (low byte). Unmapped addresses read 0.
- R7: Writing a nonzero byte to 0x38 gives exactly one cal_pulse_o cycle, and writing a nonzero byte to 0x39 gives exactly one rst_pulse_o cycle. A zero byte to either location gives no pulse.
- R8: chg_n_o is low one clock after det_status_i or key_status_i changes.
- R9: A read of address 2 or 3 releases chg_n_o (sets it high) and records the status value that was read.
- R10: If the status equals the value recorded at the last status read, a read of any address releases chg_n_o. Otherwise a read of another address leaves it low.
- R11: For BOOT_CYCLES clocks after reset, the device address is never ACKed.
- R12: After reset chg_n_o stays high. It falls CHG_CYCLES clocks after reset.
- R13: SDA is driven or released only in the clock after a synchronized SCL fall, START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| chg_n_o | output | 1 | Change flag, 0 pulls the line low |
| det_status_i | input | 8 | Detection status byte |
| key_status_i | input | NKEYS | Per-key touch flags |
| key_signal_i | input | 16*NKEYS | Key signals, key k at bits 16k+15:16k |
| key_ref_i | input | 16*NKEYS | Key references, key k at bits 16k+15:16k |
| cfg_o | output | 8*(3*NKEYS+3) | Writable setting bytes 0x20 upward |
| cal_pulse_o | output | 1 | One-cycle calibrate request |
| rst_pulse_o | output | 1 | One-cycle reset request |

## Verification
Each target response trails its SCL edge by the synchronizer depth plus one register. An ACK or a read data bit is therefore on SDA about three clocks after SCL falls. The bench holds SCL low for eight clocks before it raises it, and it samples SDA halfway through the high phase. The change output moves one clock after a status input changes, so the bench checks it two falling edges later. A read-clear takes effect when the first byte is loaded, so the bench checks it only after the STOP. Command pulses are counted every clock and compared once the write transfer has finished. The ready edge of the change output is checked a few clocks before and after the CHG_CYCLES mark.

// File: rtl/keymap_pkg.sv
package keymap_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEVADR,
      ST_DEVACK,
      ST_PTR,
      ST_PTRACK,
      ST_WDATA,
      ST_WACK,
      ST_RDATA,
      ST_RACK
   } xfer_state_t;

   localparam logic [7:0] ID_BYTE  = 8'h2E;
   localparam int         SIG_BASE = 4;
   localparam int         CFG_BASE = 32;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_o,
   output logic rise_o,
   output logic fall_o,
   output logic start_o,
   output logic stop_o
);
   if (STAGES < 2) begin : g_bad_depth
      $error("i2c_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_ff, sda_ff;
   logic              scl_d, sda_d;
   logic              scl_s, sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_d  <= scl_s;
         sda_d  <= sda_s;
      end
   end

   assign scl_s   = scl_ff[STAGES-1];
   assign sda_s   = sda_ff[STAGES-1];
   assign sda_o   = sda_s;
   assign rise_o  = scl_s & ~scl_d;
   assign fall_o  = ~scl_s & scl_d;
   assign start_o = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_o  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
   import keymap_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h1B
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ev_rise_i,
   input  logic       ev_fall_i,
   input  logic       ev_start_i,
   input  logic       ev_stop_i,
   input  logic       sda_i,
   input  logic       busy_i,
   input  logic [7:0] rd_data_i,
   output logic [7:0] rd_addr_o,
   output logic       rd_stb_o,
   output logic       wr_stb_o,
   output logic [7:0] wr_addr_o,
   output logic [7:0] wr_data_o,
   output logic       sda_low_o
);
   xfer_state_t state;
   logic [3:0]  bitcnt;
   logic [7:0]  shreg, ptr_q, last_q;
   logic        is_rd_q, addr_ok_q, mack_q;

   always_comb begin
      rd_addr_o = (state == ST_DEVACK) ? last_q : ptr_q;
      rd_stb_o  = ev_fall_i && !ev_start_i && !ev_stop_i &&
                  ((state == ST_DEVACK && is_rd_q) || (state == ST_RACK && mack_q));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bitcnt    <= '0;
         shreg     <= '0;
         ptr_q     <= '0;
         last_q    <= '0;
         is_rd_q   <= 1'b0;
         addr_ok_q <= 1'b0;
         mack_q    <= 1'b0;
         sda_low_o <= 1'b0;
         wr_stb_o  <= 1'b0;
         wr_addr_o <= '0;
         wr_data_o <= '0;
      end else begin
         wr_stb_o <= 1'b0;
         if (ev_stop_i) begin
            state     <= ST_IDLE;
            sda_low_o <= 1'b0;
         end else if (ev_start_i) begin
            state     <= ST_DEVADR;
            bitcnt    <= '0;
            sda_low_o <= 1'b0;
         end else if (rd_stb_o) begin
            shreg     <= rd_data_i;
            sda_low_o <= !rd_data_i[7];
            ptr_q     <= rd_addr_o + 8'd1;
            bitcnt    <= '0;
            state     <= ST_RDATA;
         end else begin
            case (state)
               ST_DEVADR, ST_PTR, ST_WDATA: begin
                  if (ev_rise_i) begin
                     shreg  <= {shreg[6:0], sda_i};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (ev_fall_i && bitcnt == 4'd8) begin
                     bitcnt <= '0;
                     if (state == ST_DEVADR) begin
                        if (shreg[7:1] == DEV_ADDR && !busy_i) begin
                           sda_low_o <= 1'b1;
                           is_rd_q   <= shreg[0];
                           state     <= ST_DEVACK;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else if (state == ST_PTR) begin
                        ptr_q     <= shreg;
                        last_q    <= shreg;
                        addr_ok_q <= !shreg[7];
                        sda_low_o <= !shreg[7];
                        state     <= ST_PTRACK;
                     end else begin
                        if (addr_ok_q) begin
                           sda_low_o <= 1'b1;
                           wr_stb_o  <= 1'b1;
                           wr_addr_o <= ptr_q;
                           wr_data_o <= shreg;
                           ptr_q     <= ptr_q + 8'd1;
                        end
                        state <= ST_WACK;
                     end
                  end
               end
               ST_DEVACK: if (ev_fall_i) begin
                  sda_low_o <= 1'b0;
                  bitcnt    <= '0;
                  state     <= ST_PTR;
               end
               ST_PTRACK, ST_WACK: if (ev_fall_i) begin
                  sda_low_o <= 1'b0;
                  bitcnt    <= '0;
                  state     <= ST_WDATA;
               end
               ST_RDATA: if (ev_fall_i) begin
                  if (bitcnt == 4'd7) begin
                     sda_low_o <= 1'b0;
                     bitcnt    <= '0;
                     state     <= ST_RACK;
                  end else begin
                     shreg     <= {shreg[6:0], 1'b0};
                     sda_low_o <= !shreg[6];
                     bitcnt    <= bitcnt + 4'd1;
                  end
               end
               ST_RACK: begin
                  if (ev_rise_i)      mack_q <= !sda_i;
                  else if (ev_fall_i) state  <= ST_IDLE;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/keymap_regs.sv
module keymap_regs
   import keymap_pkg::*;
#(
   parameter int         NKEYS       = 7,
   parameter logic [7:0] FW_VER      = 8'h15,
   parameter int         BOOT_CYCLES = 1_500_000,
   parameter int         CHG_CYCLES  = 5_000_000,
   localparam int        REF_BASE    = SIG_BASE + 2*NKEYS,
   localparam int        CFG_N       = 3*NKEYS + 3,
   localparam int        CAL_ADDR    = CFG_BASE + CFG_N,
   localparam int        RST_ADDR    = CAL_ADDR + 1,
   localparam int        IW          = $clog2(CFG_N),
   localparam int        CW          = $clog2(CHG_CYCLES + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [7:0]             det_i,
   input  logic [NKEYS-1:0]       key_i,
   input  logic [16*NKEYS-1:0]    sig_i,
   input  logic [16*NKEYS-1:0]    ref_i,
   input  logic [7:0]             rd_addr_i,
   input  logic                   rd_stb_i,
   input  logic                   wr_stb_i,
   input  logic [7:0]             wr_addr_i,
   input  logic [7:0]             wr_data_i,
   output logic [7:0]             rd_data_o,
   output logic [8*CFG_N-1:0]     cfg_o,
   output logic                   cal_o,
   output logic                   rst_o,
   output logic                   chg_n_o,
   output logic                   busy_o
);
   if (NKEYS < 1 || NKEYS > 7) begin : g_bad_keys
      $error("keymap_regs: NKEYS must be 1..7");
   end
   if (REF_BASE + 2*NKEYS > CFG_BASE) begin : g_bad_map
      $error("keymap_regs: value area overlaps settings");
   end
   if (CHG_CYCLES <= BOOT_CYCLES || BOOT_CYCLES < 1) begin : g_bad_timing
      $error("keymap_regs: need 0 < BOOT_CYCLES < CHG_CYCLES");
   end

   logic [7:0]  cfg_q [CFG_N];
   logic [7:0]  key_byte;
   logic [15:0] stat, stat_q, snap_q;
   logic [CW-1:0] cnt_q;
   logic        pend_q, wr_cfg, rd_cfg, stat_rd, chg_set, chg_clr;

   for (genvar i = 0; i < CFG_N; i++) begin : g_cfg_out
      assign cfg_o[8*i +: 8] = cfg_q[i];
   end

   assign key_byte = {{(8-NKEYS){1'b0}}, key_i};
   assign stat     = {det_i, key_byte};
   assign wr_cfg   = wr_stb_i && wr_addr_i >= 8'(CFG_BASE) && wr_addr_i < 8'(CAL_ADDR);
   assign rd_cfg   = rd_addr_i >= 8'(CFG_BASE) && rd_addr_i < 8'(CAL_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < CFG_N; i++) cfg_q[i] <= '0;
         cal_o <= 1'b0;
         rst_o <= 1'b0;
      end else begin
         if (wr_cfg) cfg_q[IW'(wr_addr_i - 8'(CFG_BASE))] <= wr_data_i;
         cal_o <= wr_stb_i && wr_addr_i == 8'(CAL_ADDR) && |wr_data_i;
         rst_o <= wr_stb_i && wr_addr_i == 8'(RST_ADDR) && |wr_data_i;
      end
   end

   always_comb begin
      rd_data_o = '0;
      if (rd_addr_i == 8'd0) rd_data_o = ID_BYTE;
      if (rd_addr_i == 8'd1) rd_data_o = FW_VER;
      if (rd_addr_i == 8'd2) rd_data_o = det_i;
      if (rd_addr_i == 8'd3) rd_data_o = key_byte;
      for (int k = 0; k < NKEYS; k++) begin
         if (rd_addr_i == 8'(SIG_BASE + 2*k))     rd_data_o = sig_i[16*k+8 +: 8];
         if (rd_addr_i == 8'(SIG_BASE + 2*k + 1)) rd_data_o = sig_i[16*k   +: 8];
         if (rd_addr_i == 8'(REF_BASE + 2*k))     rd_data_o = ref_i[16*k+8 +: 8];
         if (rd_addr_i == 8'(REF_BASE + 2*k + 1)) rd_data_o = ref_i[16*k   +: 8];
      end
      if (rd_cfg) rd_data_o = cfg_q[IW'(rd_addr_i - 8'(CFG_BASE))];
   end

   // Previous status sample for change detection; follows the inputs in reset too.
   always_ff @(posedge clk) stat_q <= stat;

   assign stat_rd = rd_stb_i && (rd_addr_i == 8'd2 || rd_addr_i == 8'd3);
   assign chg_set = (stat != stat_q) || (cnt_q == CW'(CHG_CYCLES - 1));
   assign chg_clr = stat_rd || (rd_stb_i && stat == snap_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
         snap_q <= '0;
      end else begin
         if (cnt_q != CW'(CHG_CYCLES)) cnt_q <= cnt_q + 1'b1;
         if (chg_set)      pend_q <= 1'b1;
         else if (chg_clr) pend_q <= 1'b0;
         if (stat_rd) snap_q <= stat;
      end
   end

   assign busy_o  = cnt_q < CW'(BOOT_CYCLES);
   assign chg_n_o = !pend_q;
endmodule

// File: rtl/keymap_i2c_target.sv
module keymap_i2c_target #(
   parameter int         NKEYS       = 7,
   parameter logic [6:0] DEV_ADDR    = 7'h1B,
   parameter logic [7:0] FW_VER      = 8'h15,
   parameter int         BOOT_CYCLES = 1_500_000,
   parameter int         CHG_CYCLES  = 5_000_000,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        scl_i,
   input  logic                        sda_i,
   output logic                        sda_oe_o,
   output logic                        chg_n_o,
   input  logic [7:0]                  det_status_i,
   input  logic [NKEYS-1:0]            key_status_i,
   input  logic [16*NKEYS-1:0]         key_signal_i,
   input  logic [16*NKEYS-1:0]         key_ref_i,
   output logic [8*(3*NKEYS+3)-1:0]    cfg_o,
   output logic                        cal_pulse_o,
   output logic                        rst_pulse_o
);
   logic       sda_s, ev_rise, ev_fall, ev_start, ev_stop, boot_busy;
   logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
   logic       rd_stb, wr_stb;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_o(sda_s), .rise_o(ev_rise), .fall_o(ev_fall),
      .start_o(ev_start), .stop_o(ev_stop)
   );

   i2c_target_fsm #(.DEV_ADDR(DEV_ADDR)) i_fsm (
      .clk(clk), .rst_n(rst_n),
      .ev_rise_i(ev_rise), .ev_fall_i(ev_fall),
      .ev_start_i(ev_start), .ev_stop_i(ev_stop),
      .sda_i(sda_s), .busy_i(boot_busy), .rd_data_i(rd_data),
      .rd_addr_o(rd_addr), .rd_stb_o(rd_stb),
      .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
      .sda_low_o(sda_oe_o)
   );

   keymap_regs #(
      .NKEYS(NKEYS), .FW_VER(FW_VER),
      .BOOT_CYCLES(BOOT_CYCLES), .CHG_CYCLES(CHG_CYCLES)
   ) i_regs (
      .clk(clk), .rst_n(rst_n),
      .det_i(det_status_i), .key_i(key_status_i),
      .sig_i(key_signal_i), .ref_i(key_ref_i),
      .rd_addr_i(rd_addr), .rd_stb_i(rd_stb),
      .wr_stb_i(wr_stb), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_data_o(rd_data), .cfg_o(cfg_o),
      .cal_o(cal_pulse_o), .rst_o(rst_pulse_o),
      .chg_n_o(chg_n_o), .busy_o(boot_busy)
   );
endmodule

// File: rtl/keymap_i2c_checks.sv
module keymap_i2c_checks #(
   parameter int NKEYS = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sda_oe,
   input logic             chg_n,
   input logic             cal_p,
   input logic             rst_p,
   input logic             busy,
   input logic             ev_fall,
   input logic             ev_start,
   input logic             ev_stop,
   input logic             wr_stb,
   input logic [7:0]       wr_addr,
   input logic [7:0]       det,
   input logic [NKEYS-1:0] key
);
   assert_boot_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sda_oe);

   assert_sda_on_fall_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_fall && !ev_start && !ev_stop) |=> $stable(sda_oe));

   assert_cal_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cal_p |=> !cal_p);

   assert_rst_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_p |=> !rst_p);

   assert_status_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ({det, key} != $past({det, key})) |=> !chg_n);

   assert_write_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> !wr_addr[7]);
endmodule

bind keymap_i2c_target keymap_i2c_checks #(.NKEYS(NKEYS)) i_checks (
   .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .chg_n(chg_n_o),
   .cal_p(cal_pulse_o), .rst_p(rst_pulse_o), .busy(boot_busy),
   .ev_fall(ev_fall), .ev_start(ev_start), .ev_stop(ev_stop),
   .wr_stb(wr_stb), .wr_addr(wr_addr),
   .det(det_status_i), .key(key_status_i)
);

// File: tb/test_keymap_i2c_target.sv
module test_keymap_i2c_target;
   localparam int CLK_PERIOD = 10;
   localparam int HP         = 8;
   localparam int NK         = 7;
   localparam int BOOT       = 400;
   localparam int CHG        = 800;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic sda_oe, chg_n, cal_p, rst_p, sda_bus;
   logic [7:0]       det = 8'h00;
   logic [NK-1:0]    key = '0;
   logic [16*NK-1:0] sig = '0, refv = '0;
   logic [8*(3*NK+3)-1:0] cfg;

   int checks = 0, failures = 0, cyc = 0, cal_cnt = 0, rst_cnt = 0;
   bit done = 0;
   logic [7:0] rbuf [0:7];
   bit         abuf [0:7];

   always #(CLK_PERIOD/2) clk = ~clk;
   assign sda_bus = sda_m & ~sda_oe;

   keymap_i2c_target #(.NKEYS(NK), .BOOT_CYCLES(BOOT), .CHG_CYCLES(CHG)) i_keymap_i2c_target (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_oe_o(sda_oe), .chg_n_o(chg_n),
      .det_status_i(det), .key_status_i(key),
      .key_signal_i(sig), .key_ref_i(refv),
      .cfg_o(cfg), .cal_pulse_o(cal_p), .rst_pulse_o(rst_p)
   );

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0; else cyc <= cyc + 1;
      if (cal_p) cal_cnt <= cal_cnt + 1;
      if (rst_p) rst_cnt <= rst_cnt + 1;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic hp();
      repeat (HP) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
   endtask

   task automatic put_byte(input logic [7:0] b, output bit acked);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0;
      end
      sda_m = 1'b1; hp(); scl_m = 1'b1;
      repeat (HP/2) @(negedge clk);
      acked = !sda_bus;
      repeat (HP/2) @(negedge clk);
      scl_m = 1'b0;
   endtask

   task automatic get_byte(input bit ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         hp(); scl_m = 1'b1;
         repeat (HP/2) @(negedge clk);
         b[i] = sda_bus;
         repeat (HP/2) @(negedge clk);
         scl_m = 1'b0;
      end
      sda_m = !ack; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0; sda_m = 1'b1;
   endtask

   // Pointer phase then a write of n bytes from rbuf; abuf[0]=device ack, [1]=pointer ack, [2..]=data acks.
   task automatic wr_regs(input logic [7:0] addr, input int n);
      bit a;
      bus_start();
      put_byte(8'h36, a); abuf[0] = a;
      put_byte(addr, a);  abuf[1] = a;
      for (int i = 0; i < n; i++) begin put_byte(rbuf[i], a); abuf[2+i] = a; end
      bus_stop();
   endtask

   // Pointer phase, repeated START, read n bytes into rbuf.
   task automatic rd_regs(input logic [7:0] addr, input int n);
      bit a;
      logic [7:0] b;
      bus_start();
      put_byte(8'h36, a); abuf[0] = a;
      put_byte(addr, a);  abuf[1] = a;
      bus_start();
      put_byte(8'h37, a); abuf[2] = a;
      for (int i = 0; i < n; i++) begin get_byte(i != n-1, b); rbuf[i] = b; end
      bus_stop();
   endtask

   // Read with no pointer phase.
   task automatic rd_cur(input int n);
      bit a;
      logic [7:0] b;
      bus_start();
      put_byte(8'h37, a); abuf[0] = a;
      for (int i = 0; i < n; i++) begin get_byte(i != n-1, b); rbuf[i] = b; end
      bus_stop();
   endtask

   task automatic t_reset();
      chk("R12 chg_n high in reset", chg_n, 1);
      chk("R11 sda released in reset", sda_oe, 0);
      chk("R7 no cal pulse in reset", cal_p, 0);
   endtask

   task automatic t_boot();
      bit a;
      bus_start();
      put_byte(8'h36, a);
      bus_stop();
      chk("R11 device address NACK during boot", a, 0);
   endtask

   task automatic t_ready_flag();
      while (cyc < CHG - 10) @(negedge clk);
      chk("R12 chg_n still high before delay", chg_n, 1);
      while (cyc < CHG + 10) @(negedge clk);
      chk("R12 chg_n low after delay", chg_n, 0);
   endtask

   task automatic t_ident();
      rd_regs(8'h00, 2);
      chk("R11 device ACK after boot", abuf[0], 1);
      chk("R6 id byte", rbuf[0], 8'h2E);
      chk("R6 firmware byte", rbuf[1], 8'h15);
      chk("R10 any read releases unchanged status", chg_n, 1);
   endtask

   task automatic t_wrong_dev();
      bit a;
      bus_start();
      put_byte(8'h38, a);
      bus_stop();
      chk("R1 foreign device address NACK", a, 0);
   endtask

   task automatic t_write_burst();
      rbuf[0] = 8'hA1; rbuf[1] = 8'hB2; rbuf[2] = 8'hC3;
      wr_regs(8'h20, 3);
      chk("R2 pointer 0x20 ACK", abuf[1], 1);
      chk("R3 data ACKs", {abuf[2], abuf[3], abuf[4]}, 3'b111);
      chk("R3 cfg byte0 on port", cfg[7:0], 8'hA1);
      chk("R3 cfg byte2 on port", cfg[23:16], 8'hC3);
      rd_regs(8'h20, 3);
      chk("R4 burst read byte0", rbuf[0], 8'hA1);
      chk("R4 burst read byte1", rbuf[1], 8'hB2);
      chk("R4 burst read byte2", rbuf[2], 8'hC3);
   endtask

   task automatic t_ptr_reuse();
      rd_regs(8'h21, 1);
      chk("R5 read after repeated start", rbuf[0], 8'hB2);
      rd_cur(2);
      chk("R5 new read restarts at last address", rbuf[0], 8'hB2);
      chk("R5 then increments", rbuf[1], 8'hC3);
   endtask

   task automatic t_readonly();
      rbuf[0] = 8'h55; wr_regs(8'h02, 1);
      chk("R3 write to status ACKed", abuf[2], 1);
      rbuf[0] = 8'h77; wr_regs(8'h3A, 1);
      chk("R3 write past command area ACKed", abuf[2], 1);
      rbuf[0] = 8'h99; wr_regs(8'h37, 1);
      rd_regs(8'h3A, 1);
      chk("R3 0x3A unchanged", rbuf[0], 8'h00);
      rd_regs(8'h02, 1);
      chk("R3 status unchanged by write", rbuf[0], 8'h00);
      rd_regs(8'h37, 1);
      chk("R3 last setting byte", rbuf[0], 8'h99);
   endtask

   task automatic t_bad_ptr();
      rbuf[0] = 8'h44; wr_regs(8'h80, 1);
      chk("R2 pointer 0x80 NACK", abuf[1], 0);
      chk("R2 data after bad pointer NACK", abuf[2], 0);
      rbuf[0] = 8'h00; wr_regs(8'h7F, 1);
      chk("R2 pointer 0x7F ACK", abuf[1], 1);
   endtask

   task automatic t_values();
      sig[16*2 +: 16]  = 16'h1234;
      refv[16*6 +: 16] = 16'hABCD;
      det = 8'h81;
      rd_regs(8'h08, 2);
      chk("R6 key2 signal high byte", rbuf[0], 8'h12);
      chk("R6 key2 signal low byte", rbuf[1], 8'h34);
      rd_regs(8'h1E, 2);
      chk("R6 key6 reference high byte", rbuf[0], 8'hAB);
      chk("R6 key6 reference low byte", rbuf[1], 8'hCD);
      rd_regs(8'h02, 1);
      chk("R6 detection status byte", rbuf[0], 8'h81);
   endtask

   task automatic t_commands();
      int c0, r0;
      c0 = cal_cnt; r0 = rst_cnt;
      rbuf[0] = 8'h00; wr_regs(8'h38, 1);
      chk("R7 zero to calibrate no pulse", cal_cnt - c0, 0);
      rbuf[0] = 8'h07; wr_regs(8'h38, 1);
      chk("R7 nonzero calibrate one pulse", cal_cnt - c0, 1);
      rbuf[0] = 8'h00; rbuf[1] = 8'h5A; wr_regs(8'h38, 2);
      chk("R7 burst zero then reset: no cal", cal_cnt - c0, 1);
      chk("R7 burst zero then reset: one reset", rst_cnt - r0, 1);
   endtask

   task automatic t_change();
      chk("R9 released after status read", chg_n, 1);
      key = 7'h04;
      @(negedge clk); @(negedge clk);
      chk("R8 chg_n low after key change", chg_n, 0);
      rd_regs(8'h00, 1);
      chk("R10 other read keeps flag while status differs", chg_n, 0);
      rd_regs(8'h03, 1);
      chk("R6 key status byte", rbuf[0], 8'h04);
      chk("R9 key status read releases", chg_n, 1);
      key = 7'h05; repeat (4) @(negedge clk);
      key = 7'h04; repeat (4) @(negedge clk);
      chk("R8 flag stays low after touch and release", chg_n, 0);
      rd_regs(8'h20, 1);
      chk("R10 any read releases returned status", chg_n, 1);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_boot();
      t_ready_flag();
      t_ident();
      t_wrong_dev();
      t_write_burst();
      t_ptr_reuse();
      t_readonly();
      t_bad_ptr();
      t_values();
      t_commands();
      t_change();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog (R4 transfer hung) actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule